// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block sits on the receive side of a MAC and watches each incoming frame one byte at a time. It decides whether the frame is a MAC-control PAUSE request, and when it is, it reports the requested pause time to the transmit side. The frame arrives as a byte stream qualified by a valid strobe, with start and end markers. A frame-good status comes with the last byte. The block checks the destination address, the EtherType and the control opcode. It ignores the source address and captures the 16-bit pause time that follows the opcode.

Detection is allowed only while the link runs full duplex and receive flow control is enabled. Both enables are sampled on the cycle that carries the last byte. The destination may be either the reserved control multicast address or the station's own programmed address. One cycle after the last byte of a qualifying frame, a single-cycle pulse appears and the captured pause time is presented with it. That value stays on the output until the next detection.

Top module: `pause_frame_detector`

## Requirements
- R1: After reset, `pause_det` is 0 and `pause_quanta` is 0x0000.
- R2: A frame whose bytes 0..5 are 01,80,C2,00,00,01 passes the destination check; any other address that is not the station address fails it.
- R3: A frame whose bytes 0..5 equal `station_addr` (byte 0 = bits 47:40, byte 5 = bits 7:0) passes the destination check; a single differing bit fails it.
- R4: Bytes 6..11 (source address) have no effect on detection.
- R5: Bytes 12..13 must be 0x88 then 0x08, or the frame is not detected.
- R6: Bytes 14..15 must be 0x00 then 0x01, or the frame is not detected.
- R7: Bytes 16..17 are captured as the pause time (byte 16 = bits 15:8); any value 0x0000..0xFFFF is accepted, and `pause_quanta` holds its value until the next detection.
- R8: No detection occurs unless both `full_duplex_en` and `flow_ctrl_en` are 1 in the cycle that carries the end-of-frame byte.
- R9: No detection occurs unless `rx_good` is 1 in the cycle that carries the end-of-frame byte.
- R10: A detection is a single-cycle `pause_det` pulse in the cycle right after the end-of-frame byte is accepted.
- R11: A frame with fewer than 18 bytes never matches; bytes after byte 17 (padding) do not prevent a match.
- R12: Each start-of-frame byte restarts the comparison at byte 0; bytes with `rx_valid` low are skipped; bytes after an end of frame and before the next start are ignored; back-to-back frames are each judged on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_sof | input | 1 | Current byte is the first byte of a frame |
| rx_eof | input | 1 | Current byte is the last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_good | input | 1 | Frame status, valid with the end-of-frame byte |
| station_addr | input | 48 | Station's own address, first wire byte in bits 47:40 |
| full_duplex_en | input | 1 | Link operates full duplex |
| flow_ctrl_en | input | 1 | Receive flow control enabled |
| pause_det | output | 1 | One-cycle pulse when a PAUSE frame is detected |
| pause_quanta | output | 16 | Pause time of the most recently detected frame |

## Verification
The embedded assertions watch every cycle. A pulse must follow an accepted end-of-frame byte taken at byte 17 or later. The enables and the good status must have been high on that byte. Pulses are never adjacent, and the pause-time output changes only together with a pulse. Which field values, address choices, gaps, stray bytes and back-to-back timings actually produce or suppress a detection can only be shown by the bench's frame scenarios, which compare the pulse count and the captured time against values built from the requirements.

// File: rtl/pause_frame_detector.sv
module pause_frame_detector #(
  parameter logic [47:0] CTRL_DA   = 48'h0180_C200_0001,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP  = 16'h0001,
  parameter int          POS_W     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_good,
  input  logic [47:0] station_addr,
  input  logic        full_duplex_en,
  input  logic        flow_ctrl_en,
  output logic        pause_det,
  output logic [15:0] pause_quanta
);
  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(17);

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [POS_W-1:0] k);
    case (k)
      POS_W'(0): addr_byte = a[47:40];
      POS_W'(1): addr_byte = a[39:32];
      POS_W'(2): addr_byte = a[31:24];
      POS_W'(3): addr_byte = a[23:16];
      POS_W'(4): addr_byte = a[15:8];
      POS_W'(5): addr_byte = a[7:0];
      default:   addr_byte = 8'h00;
    endcase
  endfunction

  logic             in_frame;
  logic [POS_W-1:0] pos_q;
  logic             mc_ok, st_ok, ty_ok, op_ok;
  logic [15:0]      dur_q;

  logic             n_mc, n_st, n_ty, n_op;
  logic [15:0]      n_dur;
  logic             verdict;

  wire              take = rx_valid && (rx_sof || in_frame);
  wire [POS_W-1:0]  pos  = rx_sof ? '0 : pos_q;
  wire              long_enough = (pos >= POS_LAST);

  always_comb begin
    n_mc  = rx_sof ? 1'b1 : mc_ok;
    n_st  = rx_sof ? 1'b1 : st_ok;
    n_ty  = rx_sof ? 1'b1 : ty_ok;
    n_op  = rx_sof ? 1'b1 : op_ok;
    n_dur = dur_q;
    if (pos < POS_W'(6)) begin
      n_mc = n_mc && (rx_data == addr_byte(CTRL_DA, pos));
      n_st = n_st && (rx_data == addr_byte(station_addr, pos));
    end
    case (pos)
      POS_W'(12): n_ty = n_ty && (rx_data == CTRL_TYPE[15:8]);
      POS_W'(13): n_ty = n_ty && (rx_data == CTRL_TYPE[7:0]);
      POS_W'(14): n_op = n_op && (rx_data == PAUSE_OP[15:8]);
      POS_W'(15): n_op = n_op && (rx_data == PAUSE_OP[7:0]);
      POS_W'(16): n_dur[15:8] = rx_data;
      POS_W'(17): n_dur[7:0]  = rx_data;
      default: ;
    endcase
  end

  assign verdict = take && rx_eof && long_enough && (n_mc || n_st) && n_ty && n_op &&
                   rx_good && full_duplex_en && flow_ctrl_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame     <= 1'b0;
      pos_q        <= '0;
      mc_ok        <= 1'b0;
      st_ok        <= 1'b0;
      ty_ok        <= 1'b0;
      op_ok        <= 1'b0;
      dur_q        <= '0;
      pause_det    <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_det <= verdict;
      if (verdict) pause_quanta <= n_dur;
      if (take) begin
        in_frame <= !rx_eof;
        pos_q    <= (pos == POS_MAX) ? pos : pos + POS_W'(1);
        mc_ok    <= n_mc;
        st_ok    <= n_st;
        ty_ok    <= n_ty;
        op_ok    <= n_op;
        dur_q    <= n_dur;
      end
    end
  end

  AST_PULSE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    pause_det |-> $past(rx_valid && rx_eof)); // R10
  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_det |=> !pause_det); // R10
  AST_ENABLES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pause_det |-> $past(full_duplex_en && flow_ctrl_en)); // R8
  AST_GOOD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pause_det |-> $past(rx_good)); // R9
  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    pause_det |-> $past(!rx_sof && in_frame && pos_q >= POS_LAST)); // R11
  AST_QUANTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pause_quanta) |-> pause_det); // R7
endmodule

// File: tb/pause_frame_detector_tb.sv
module pause_frame_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        full_duplex_en = 1'b0, flow_ctrl_en = 1'b0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic        pause_det;
  logic [15:0] pause_quanta;

  always #5 clk = ~clk;

  pause_frame_detector dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_good(rx_good), .station_addr(station_addr),
    .full_duplex_en(full_duplex_en), .flow_ctrl_en(flow_ctrl_en),
    .pause_det(pause_det), .pause_quanta(pause_quanta));

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  logic [15:0] last_q = '0;

  localparam logic [47:0] MC = 48'h0180_C200_0001;
  localparam logic [47:0] ST = 48'h02_11_22_33_44_55;
  localparam logic [47:0] SA = 48'h00_0A_0B_0C_0D_0E;
  localparam int NV = 14;
  // {da, sa, type, opcode, dur, len, good, fd, fce, expect}
  localparam logic [155:0] VEC [NV] = '{
    {MC, SA, 16'h8808, 16'h0001, 16'h1234, 8'd18, 1'b1, 1'b1, 1'b1, 1'b1},
    {ST, SA, 16'h8808, 16'h0001, 16'h0000, 8'd18, 1'b1, 1'b1, 1'b1, 1'b1},
    {MC, SA, 16'h8808, 16'h0001, 16'hFFFF, 8'd64, 1'b1, 1'b1, 1'b1, 1'b1},
    {48'h0180_C200_0002, SA, 16'h8808, 16'h0001, 16'h1111, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0},
    {48'h02_11_22_33_44_54, SA, 16'h8808, 16'h0001, 16'h2222, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0},
    {MC, SA, 16'h8809, 16'h0001, 16'h3333, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0},
    {MC, SA, 16'h8808, 16'h0002, 16'h4444, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0},
    {MC, SA, 16'h8808, 16'h0001, 16'h5555, 8'd18, 1'b0, 1'b1, 1'b1, 1'b0},
    {MC, SA, 16'h8808, 16'h0001, 16'h6666, 8'd18, 1'b1, 1'b0, 1'b1, 1'b0},
    {MC, SA, 16'h8808, 16'h0001, 16'h7777, 8'd18, 1'b1, 1'b1, 1'b0, 1'b0},
    {MC, SA, 16'h8808, 16'h0001, 16'h8888, 8'd17, 1'b1, 1'b1, 1'b1, 1'b0},
    {ST, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0001, 16'hABCD, 8'd20, 1'b1, 1'b1, 1'b1, 1'b1},
    {MC, SA, 16'h8808, 16'h0101, 16'h9999, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0},
    {MC, SA, 16'h0808, 16'h0001, 16'hAAAA, 8'd18, 1'b1, 1'b1, 1'b1, 1'b0}};

  function automatic string vtag(int k);
    case (k)
      0: vtag = "R2"; 1: vtag = "R3"; 2: vtag = "R7"; 3: vtag = "R2"; 4: vtag = "R3";
      5: vtag = "R5"; 6: vtag = "R6"; 7: vtag = "R9"; 8: vtag = "R8"; 9: vtag = "R8";
      10: vtag = "R11"; 11: vtag = "R4"; 12: vtag = "R6"; default: vtag = "R5";
    endcase
  endfunction

  function automatic logic [7:0] fb(logic [155:0] v, int i);
    logic [47:0] da = v[155:108];
    logic [47:0] sa = v[107:60];
    if (i < 6) fb = da[8*(5-i) +: 8];
    else if (i < 12) fb = sa[8*(11-i) +: 8];
    else if (i < 14) fb = v[59:44] >> (8*(13-i));
    else if (i < 16) fb = v[43:28] >> (8*(15-i));
    else if (i < 18) fb = v[27:12] >> (8*(17-i));
    else fb = 8'(i) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [155:0] v, input bit sof_on, input bit gaps, input bit idle);
    int len = int'(v[11:4]);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = sof_on && (i == 0); rx_eof = (i == len - 1);
      rx_data = fb(v, i); rx_good = v[3]; full_duplex_en = v[2]; flow_ctrl_en = v[1];
    end
    if (idle) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // pulse monitor, sampled 2 ns after the active edge
  always @(posedge clk) begin
    #2;
    if (rst_n && pause_det) begin
      pulses++;
      last_q = pause_quanta;
      check(rx_valid && rx_eof, "R10 pulse follows eof byte", 0, 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R10: watchdog expired, actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check(pause_det == 1'b0, "R1 pause_det", int'(pause_det), 0);
    check(pause_quanta == 16'h0, "R1 pause_quanta", int'(pause_quanta), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      p0 = pulses;
      held = pause_quanta;
      send(VEC[k], 1'b1, 1'b0, 1'b1);
      check((pulses - p0) == int'(VEC[k][0]), vtag(k), pulses - p0, int'(VEC[k][0]));
      if (VEC[k][0]) check(last_q == VEC[k][27:12], {vtag(k), " R7 quanta"}, int'(last_q), int'(VEC[k][27:12]));
      else check(pause_quanta == held, {vtag(k), " R7 hold"}, int'(pause_quanta), int'(held));
    end

    // R12: gaps inside frame
    p0 = pulses;
    send(VEC[0], 1'b1, 1'b1, 1'b1);
    check(pulses - p0 == 1 && last_q == 16'h1234, "R12 gaps", pulses - p0, 1);

    // R12: back-to-back frames
    p0 = pulses;
    send(VEC[1], 1'b1, 1'b0, 1'b0);
    send(VEC[11], 1'b1, 1'b0, 1'b1);
    check(pulses - p0 == 2, "R12 back-to-back count", pulses - p0, 2);
    check(last_q == 16'hABCD, "R12 back-to-back quanta", int'(last_q), 16'hABCD);

    // R12: bytes outside any frame are ignored
    p0 = pulses;
    send(VEC[2], 1'b0, 1'b0, 1'b1);
    check(pulses - p0 == 0, "R12 no sof ignored", pulses - p0, 0);
    check(pause_quanta == 16'hABCD, "R12 quanta untouched", int'(pause_quanta), 16'hABCD);

    // R12: sof in mid frame restarts comparison
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'h77;
    end
    send(VEC[0], 1'b1, 1'b0, 1'b1);
    check(pulses - p0 == 1 && last_q == 16'h1234, "R12 restart", pulses - p0, 1);

    // R11: one-byte frame
    p0 = pulses;
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h01; rx_good = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (2) @(negedge clk);
    check(pulses - p0 == 0, "R11 single byte", pulses - p0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule